// File: doc/BRIEF.md
# Power supply fault supervisor

This block watches the health of a four-channel power supply and decides which channels may run. It receives digitized readings of the supply voltage at two sense points and a digitized die temperature. It also receives one over-voltage and one over-current indication per channel. Each supply reading is compared with two programmable thresholds. The upper threshold raises a warning. The lower threshold raises a fault. Readings and thresholds are 8-bit codes, one code step per 100 mV.

Every detected condition sets a sticky flag. A flag stays set until the host writes a one to its clear bit. The host alert pin is the OR of all flags whose mask bit is low.

Fault scope and recovery depend on the fault type:
- An under-voltage fault or an over-temperature fault turns off every channel.
- An over-voltage or over-current indication turns off only its own channel.
- Under-voltage, over-temperature and over-voltage shutdowns hold until the host clears the flag.
- An over-current shutdown ends by itself. The channel restarts after a programmable delay (200 ms by default), timed by a prescaled tick. A new over-current during the wait starts the delay again.

All inputs are level samples taken on every clock. No data is queued or transferred, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `pwr_fault_sup`

## Requirements
- R1: After reset all warning and fault flags are 0, every `ch_on` bit is 1, `alert` is 0 and `ch_restart` is 0.
- R2: When `vin_code[i]` is at or below `warn_thr[i]` (unsigned codes, 1 LSB = 100 mV), `warn_flags[i]` is 1 from the next clock edge. A reading one code above the threshold sets nothing.
- R3: When `vin_code[i]` is at or below `fault_thr[i]`, `fault_flags[i]` is 1 from the next edge. While that flag is set, every `ch_on` bit is 0.
- R4: When `temp_code` is at or above `temp_limit`, `fault_flags[NUM_VIN]` is 1 from the next edge. While that flag is set, every `ch_on` bit is 0.
- R5: `ovp_in[c]` sets `fault_flags[NUM_VIN+1+c]`. From the next edge only `ch_on[c]` is 0. It stays 0 after the indication goes away, until the host clears that flag.
- R6: `ocp_in[c]` sets `fault_flags[NUM_VIN+1+NUM_CH+c]`. From the next edge only `ch_on[c]` is 0.
- R7: After the last cycle with `ocp_in[c]` high, `ch_on[c]` returns to 1 by itself after between RESTART_MS-1 and RESTART_MS tick periods. In that same cycle `ch_restart[c]` pulses high for exactly one cycle. The over-current flag stays set.
- R8: An over-current on a channel that is already waiting starts its delay again from that point.
- R9: Flags are cleared by write-one-to-clear. `flag_clr` has the same layout as `alert_mask`: warning bits in `[NUM_VIN-1:0]`, fault bit k at `NUM_VIN+k`. A flag clears on the next edge only if its condition is absent. If the condition is present, the set wins. Other flags are not affected.
- R10: `alert` is 1 exactly when some flag is set whose `alert_mask` bit (same layout as `flag_clr`) is 0. A mask bit of 1 hides the flag from the alert but leaves the flag itself set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| vin_code | input | NUM_VIN x 8 | Supply readings, 100 mV per code |
| warn_thr | input | NUM_VIN x 8 | Warning thresholds |
| fault_thr | input | NUM_VIN x 8 | Fault thresholds |
| temp_code | input | 8 | Temperature reading |
| temp_limit | input | 8 | Over-temperature limit |
| ovp_in | input | NUM_CH | Per-channel over-voltage indication |
| ocp_in | input | NUM_CH | Per-channel over-current indication |
| flag_clr | input | NUM_VIN+1+2*NUM_CH+NUM_VIN | Write-one-to-clear strobes for the flags |
| alert_mask | input | NUM_VIN+1+2*NUM_CH+NUM_VIN | 1 = flag does not drive the alert |
| warn_flags | output | NUM_VIN | Sticky warning flags |
| fault_flags | output | NUM_VIN+1+2*NUM_CH | Sticky fault flags (UV, OT, OV per channel, OC per channel) |
| ch_on | output | NUM_CH | 1 = channel allowed to run |
| ch_restart | output | NUM_CH | One-cycle pulse when an over-current wait ends |
| alert | output | 1 | Host alert |

## Verification
The bench drives readings that sit exactly on a threshold and one code above it, to catch a strict compare that would miss the boundary. It clears flags both while their condition is still present and after it has gone. A design that let the clear win would drop a live fault and re-enable channels under it. For over-current, the bench checks the channel just before and just after the restart window. It also fires a second event partway through the wait, which a timer that never reloads would answer by restarting early. It checks that channel faults leave neighbouring channels running, and that masking changes only the alert, not the flag.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int unsigned VCODE_W = 8;
  typedef logic [VCODE_W-1:0] vcode_t;
endpackage

// File: rtl/pfs_tick.sv
module pfs_tick #(
  parameter int unsigned DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/pfs_flag_cell.sv
module pfs_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/pfs_ocp_timer.sv
module pfs_ocp_timer #(
  parameter int unsigned TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ocp_i,
  input  logic tick_i,
  output logic hold_o,
  output logic restart_o
);
  localparam int unsigned TW = $clog2(TICKS + 1);
  logic [TW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain    <= '0;
      hold_o    <= 1'b0;
      restart_o <= 1'b0;
    end else begin
      restart_o <= 1'b0;
      if (ocp_i) begin
        remain <= TW'(TICKS);
        hold_o <= 1'b1;
      end else if (hold_o && tick_i) begin
        if (remain <= TW'(1)) begin
          remain    <= '0;
          hold_o    <= 1'b0;
          restart_o <= 1'b1;
        end else begin
          remain <= remain - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pwr_fault_sup.sv
module pwr_fault_sup #(
  parameter int unsigned NUM_VIN    = 2,
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned CLK_HZ     = 200_000_000,
  parameter int unsigned TICK_HZ    = 1000,
  parameter int unsigned RESTART_MS = 200,
  localparam int unsigned NFAULT    = NUM_VIN + 1 + 2 * NUM_CH,
  localparam int unsigned NFLAG     = NUM_VIN + NFAULT
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  pfs_pkg::vcode_t [NUM_VIN-1:0]         vin_code,
  input  pfs_pkg::vcode_t [NUM_VIN-1:0]         warn_thr,
  input  pfs_pkg::vcode_t [NUM_VIN-1:0]         fault_thr,
  input  pfs_pkg::vcode_t                       temp_code,
  input  pfs_pkg::vcode_t                       temp_limit,
  input  logic [NUM_CH-1:0]                     ovp_in,
  input  logic [NUM_CH-1:0]                     ocp_in,
  input  logic [NFLAG-1:0]                      flag_clr,
  input  logic [NFLAG-1:0]                      alert_mask,
  output logic [NUM_VIN-1:0]                    warn_flags,
  output logic [NFAULT-1:0]                     fault_flags,
  output logic [NUM_CH-1:0]                     ch_on,
  output logic [NUM_CH-1:0]                     ch_restart,
  output logic                                  alert
);
  localparam int unsigned DIV     = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;
  localparam int unsigned TICKS   = (RESTART_MS * TICK_HZ / 1000 > 0) ? RESTART_MS * TICK_HZ / 1000 : 1;
  localparam int unsigned OT_BIT  = NUM_VIN;
  localparam int unsigned OV_BASE = NUM_VIN + 1;
  localparam int unsigned OC_BASE = NUM_VIN + 1 + NUM_CH;

  logic [NFLAG-1:0]  set_v;
  logic [NFLAG-1:0]  flags;
  logic [NUM_CH-1:0] oc_hold;
  logic              tick;
  logic              global_off;

  pfs_tick #(.DIV(DIV)) tick_i (.clk(clk), .rst_n(rst_n), .tick(tick));

  // condition detection for every flag, in flag_clr layout
  always_comb begin
    set_v = '0;
    for (int i = 0; i < NUM_VIN; i++) begin
      set_v[i]           = (vin_code[i] <= warn_thr[i]);
      set_v[NUM_VIN + i] = (vin_code[i] <= fault_thr[i]);
    end
    set_v[NUM_VIN + OT_BIT] = (temp_code >= temp_limit);
    for (int c = 0; c < NUM_CH; c++) begin
      set_v[NUM_VIN + OV_BASE + c] = ovp_in[c];
      set_v[NUM_VIN + OC_BASE + c] = ocp_in[c];
    end
  end

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag
    pfs_flag_cell cell_i (
      .clk(clk), .rst_n(rst_n), .set_i(set_v[f]), .clr_i(flag_clr[f]), .flag_o(flags[f])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pfs_ocp_timer #(.TICKS(TICKS)) oc_tmr_i (
      .clk(clk), .rst_n(rst_n), .ocp_i(ocp_in[c]), .tick_i(tick),
      .hold_o(oc_hold[c]), .restart_o(ch_restart[c])
    );
    assign ch_on[c] = !global_off && !fault_flags[OV_BASE + c] && !oc_hold[c];
  end

  assign warn_flags  = flags[NUM_VIN-1:0];
  assign fault_flags = flags[NFLAG-1:NUM_VIN];
  assign global_off  = |fault_flags[OT_BIT:0];
  assign alert       = |(flags & ~alert_mask);
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
  parameter int unsigned NUM_VIN = 2,
  parameter int unsigned NUM_CH  = 4,
  localparam int unsigned NFAULT = NUM_VIN + 1 + 2 * NUM_CH,
  localparam int unsigned NFLAG  = NUM_VIN + NFAULT
) (
  input logic                          clk,
  input logic                          rst_n,
  input pfs_pkg::vcode_t [NUM_VIN-1:0] vin_code,
  input pfs_pkg::vcode_t [NUM_VIN-1:0] warn_thr,
  input logic [NUM_CH-1:0]             ocp_in,
  input logic [NFLAG-1:0]              flag_clr,
  input logic [NUM_VIN-1:0]            warn_flags,
  input logic [NFAULT-1:0]             fault_flags,
  input logic [NUM_CH-1:0]             ch_on,
  input logic [NUM_CH-1:0]             ch_restart,
  input logic                          alert
);
  for (genvar i = 0; i < NUM_VIN; i++) begin : g_vin
    p_warn_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (vin_code[i] <= warn_thr[i]) |=> warn_flags[i]);
    p_warn_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (warn_flags[i] && !flag_clr[i]) |=> warn_flags[i]);
  end

  p_global_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_flags[NUM_VIN:0]) |-> (ch_on == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    p_ovp_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fault_flags[NUM_VIN + 1 + c] |-> !ch_on[c]);
    p_ocp_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ocp_in[c] |=> !ch_on[c]);
    p_restart_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ch_restart[c] |-> (!$past(ocp_in[c]) && fault_flags[NUM_VIN + 1 + NUM_CH + c]));
    p_restart_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ch_restart[c] |=> !ch_restart[c]);
  end

  p_alert_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    alert |-> ((|warn_flags) || (|fault_flags)));
endmodule

bind pwr_fault_sup pfs_checker #(.NUM_VIN(NUM_VIN), .NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .vin_code(vin_code), .warn_thr(warn_thr), .ocp_in(ocp_in),
  .flag_clr(flag_clr), .warn_flags(warn_flags), .fault_flags(fault_flags),
  .ch_on(ch_on), .ch_restart(ch_restart), .alert(alert)
);

// File: tb/pwr_fault_sup_tb.sv
module pwr_fault_sup_tb_top;
  localparam int unsigned NV = 2;
  localparam int unsigned NC = 4;
  localparam int unsigned NF = NV + 1 + 2 * NC;
  localparam int unsigned NL = NV + NF;
  localparam int unsigned DIVT = 10;
  localparam int unsigned TK = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  pfs_pkg::vcode_t [NV-1:0] vin_code, warn_thr, fault_thr;
  pfs_pkg::vcode_t temp_code, temp_limit;
  logic [NC-1:0] ovp_in, ocp_in, ch_on, ch_restart;
  logic [NL-1:0] flag_clr, alert_mask;
  logic [NV-1:0] warn_flags;
  logic [NF-1:0] fault_flags;
  logic alert;

  int checks = 0;
  int fails = 0;
  int rst_cnt [NC];
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_fault_sup #(.NUM_VIN(NV), .NUM_CH(NC), .CLK_HZ(10_000), .TICK_HZ(1000), .RESTART_MS(TK)) dut_i (
    .clk(clk), .rst_n(rst_n), .vin_code(vin_code), .warn_thr(warn_thr), .fault_thr(fault_thr),
    .temp_code(temp_code), .temp_limit(temp_limit), .ovp_in(ovp_in), .ocp_in(ocp_in),
    .flag_clr(flag_clr), .alert_mask(alert_mask), .warn_flags(warn_flags),
    .fault_flags(fault_flags), .ch_on(ch_on), .ch_restart(ch_restart), .alert(alert)
  );

  always @(posedge clk) if (rst_n) for (int c = 0; c < NC; c++) if (ch_restart[c]) rst_cnt[c]++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear(input logic [NL-1:0] bits);
    flag_clr = bits;
    cyc();
    flag_clr = '0;
  endtask

  task automatic t_reset;
    check("R1 warn", 32'(warn_flags), 0);
    check("R1 fault", 32'(fault_flags), 0);
    check("R1 ch_on", 32'(ch_on), 32'hF);
    check("R1 alert", 32'(alert), 0);
    check("R1 restart", 32'(ch_restart), 0);
  endtask

  task automatic t_warn;
    vin_code[1] = 8'd46; cyc();
    check("R2 above threshold", 32'(warn_flags), 0);
    vin_code[1] = 8'd45; cyc();
    check("R2 at threshold", 32'(warn_flags), 32'h2);
    check("R2 no fault", 32'(fault_flags), 0);
    check("R2 channels run", 32'(ch_on), 32'hF);
    check("R10 alert", 32'(alert), 1);
    clear(NL'(2)); check("R9 set wins", 32'(warn_flags), 32'h2);
    vin_code[1] = 8'd50; cyc();
    check("R9 sticky", 32'(warn_flags), 32'h2);
    clear(NL'(2));
    check("R9 cleared", 32'(warn_flags), 0);
    check("R10 alert drop", 32'(alert), 0);
  endtask

  task automatic t_uv;
    vin_code[0] = 8'd40; cyc();
    check("R3 uv fault", 32'(fault_flags), 32'h1);
    check("R3 all off", 32'(ch_on), 0);
    vin_code[0] = 8'd50; cyc(3);
    check("R3 latched", 32'(ch_on), 0);
    clear(NL'(1) << NV);
    check("R9 fault clear keeps warn", 32'(warn_flags), 32'h1);
    check("R3 back on", 32'(ch_on), 32'hF);
    clear(NL'(1));
  endtask

  task automatic t_otp;
    temp_code = 8'd124; cyc();
    check("R4 below limit", 32'(fault_flags), 0);
    temp_code = 8'd125; cyc();
    check("R4 ot fault", 32'(fault_flags), 32'h4);
    check("R4 all off", 32'(ch_on), 0);
    temp_code = 8'd60;
    clear(NL'(1) << (NV + 2));
    check("R4 back on", 32'(ch_on), 32'hF);
  endtask

  task automatic t_ovp;
    ovp_in[2] = 1'b1; cyc(); ovp_in[2] = 1'b0;
    check("R5 ov flag", 32'(fault_flags), 32'h1 << 5);
    check("R5 only ch2", 32'(ch_on), 32'hB);
    cyc(10);
    check("R5 latched", 32'(ch_on), 32'hB);
    clear(NL'(1) << (NV + 5));
    check("R5 released", 32'(ch_on), 32'hF);
  endtask

  task automatic t_ocp;
    ocp_in[1] = 1'b1; cyc(); ocp_in[1] = 1'b0;
    check("R6 oc flag", 32'(fault_flags), 32'h1 << 8);
    check("R6 only ch1", 32'(ch_on), 32'hD);
    cyc((TK - 1) * DIVT - 6);
    check("R7 still waiting", 32'(ch_on), 32'hD);
    check("R7 no early pulse", 32'(rst_cnt[1]), 0);
    cyc(20);
    check("R7 restarted", 32'(ch_on), 32'hF);
    check("R7 one pulse", 32'(rst_cnt[1]), 1);
    check("R7 flag kept", 32'(fault_flags), 32'h1 << 8);
    clear(NL'(1) << (NV + 8));
  endtask

  task automatic t_retrig;
    ocp_in[3] = 1'b1; cyc(); ocp_in[3] = 1'b0;
    cyc(1000);
    ocp_in[3] = 1'b1; cyc(); ocp_in[3] = 1'b0;
    cyc(TK * DIVT - 1000 + 20);
    check("R8 delay restarted", 32'(ch_on), 32'h7);
    check("R8 no pulse", 32'(rst_cnt[3]), 0);
    cyc(1000);
    check("R8 restarted", 32'(ch_on), 32'hF);
    check("R8 one pulse", 32'(rst_cnt[3]), 1);
    clear(NL'(1) << (NV + 10));
  endtask

  task automatic t_mask;
    alert_mask = NL'(1);
    vin_code[0] = 8'd45; cyc(); vin_code[0] = 8'd50;
    check("R10 masked flag set", 32'(warn_flags), 32'h1);
    check("R10 masked alert", 32'(alert), 0);
    alert_mask = '0; #1;
    check("R10 unmasked alert", 32'(alert), 1);
    clear(NL'(1));
    check("R10 final clear", 32'(alert), 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int c = 0; c < NC; c++) rst_cnt[c] = 0;
    vin_code = {8'd50, 8'd50}; warn_thr = {8'd45, 8'd45}; fault_thr = {8'd40, 8'd40};
    temp_code = 8'd60; temp_limit = 8'd125;
    ovp_in = '0; ocp_in = '0; flag_clr = '0; alert_mask = '0;
    cyc(3); rst_n = 1'b1; cyc();
    t_reset();
    t_warn();
    t_uv();
    t_otp();
    t_ovp();
    t_ocp();
    t_retrig();
    t_mask();
    finish_run();
  end
endmodule